// File: doc/BRIEF.md
# EEPROM boot source selector

This block decides, right after reset, how the device starts up. It fetches the first byte of an attached serial EEPROM through a byte-read request handshake and treats that byte as a boot marker. One marker value makes the block read a vendor, product and release identity from the EEPROM. A second marker value makes it read a small header and copy a stream of EEPROM bytes into internal RAM. Any other value, or no EEPROM at all, leaves the built-in identity in place.

The serial bus engine sits outside the block. The block raises a read request with a 16-bit EEPROM byte address. The engine answers with a one-cycle acknowledge that carries the data byte, or with a one-cycle no-acknowledge flag. The block keeps the processor in reset until its chosen path has finished. It then presents the final identity values, the boot mode and an error flag, and these stay fixed until the next reset.

Top module: `eeprom_boot_sel`

## Requirements
- R1: After reset is released, `cpuHold` is 1, `bootDone` is 0, `bootMode` is 0, and a read request is raised for EEPROM address 0.
- R2: A pending read keeps `rdAddr` stable until `rdAck` or `rdNak` is seen. The block reads consecutive addresses starting at 0 and never skips or repeats one.
- R3: A marker byte of 0xC0 makes the block read addresses 1 to 6 as vendor ID, product ID and release ID, each with the low byte first. It then finishes with `bootMode` = 1 (encoding 0 = built-in IDs, 1 = IDs from EEPROM, 2 = RAM load) and `bootErr` = 0.
- R4: A marker byte of 0xC2 makes the block read a header: length low/high at addresses 1 and 2, start address low/high at addresses 3 and 4. EEPROM byte 5+k is then written to RAM address start+k for k = 0 to length-1, one write strobe per byte. The block finishes with `bootMode` = 2 and keeps the built-in IDs.
- R5: Any other marker value ends the sequence after that single read, with the built-in IDs, `bootMode` = 0 and `bootErr` = 0.
- R6: A no-acknowledge on the marker read (no EEPROM present) ends with the built-in IDs, `bootMode` = 0 and `bootErr` = 0.
- R7: A no-acknowledge on any later read ends the sequence at once. The result is the built-in IDs, `bootMode` = 0 and `bootErr` = 1, with no RAM write after the failed read.
- R8: When start+length exceeds the RAM depth (16384 bytes), the block writes no RAM and ends with the built-in IDs, `bootMode` = 0 and `bootErr` = 1. A load that ends exactly at the last RAM byte is accepted. A length of 0 ends with `bootMode` = 2 and no writes.
- R9: The built-in identity is vendor 0x04B4, product 0x8613 and release 0xA000 plus the 12-bit chip revision (0xA001 by default).
- R10: `bootDone` rises only after the last RAM write strobe, stays high until reset, and always equals the inverse of `cpuHold`. While `bootDone` is high the block raises no read request and no write strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdReq | output | 1 | EEPROM byte read request |
| rdAddr | output | 16 | EEPROM byte address of the request |
| rdAck | input | 1 | One-cycle read completion with valid `rdData` |
| rdNak | input | 1 | One-cycle no-acknowledge / no device |
| rdData | input | 8 | Byte returned with `rdAck` |
| ramWe | output | 1 | Internal RAM write strobe |
| ramAddr | output | 14 | Internal RAM write address |
| ramData | output | 8 | Internal RAM write data |
| vendorId | output | 16 | Selected vendor ID |
| productId | output | 16 | Selected product ID |
| releaseId | output | 16 | Selected release ID |
| bootMode | output | 2 | 0 built-in IDs, 1 EEPROM IDs, 2 RAM load |
| bootErr | output | 1 | Sequence aborted by no-acknowledge or range error |
| bootDone | output | 1 | Boot choice complete |
| cpuHold | output | 1 | Processor held in reset while 1 |

## Verification
A wrong byte index or address counter shows up at the read port within one transfer: the responder sees an address other than the count of bytes already served. A corrupted write pointer shows as a wrong `ramAddr` on the very next strobe. A wrong state decode shows at completion, as the wrong total number of reads, a wrong mode or error flag, IDs that differ from the computed set, or a hold that is never released. The no-acknowledge position and the load window are swept so that each abort path and each range edge is reached.

// File: rtl/ebs_pkg.sv
package ebs_pkg;

  typedef enum logic [2:0] {
    S_MARK, S_IDS, S_HDR, S_CHECK, S_DATA, S_FLUSH, S_DONE
  } bootState_t;

  typedef enum logic [1:0] {
    MODE_DEFAULT = 2'b00,
    MODE_IDS     = 2'b01,
    MODE_LOAD    = 2'b10
  } bootMode_t;

  // control-to-datapath strobes
  typedef struct packed {
    logic nextAddr;    // advance EEPROM address
    logic clrCnt;      // restart byte index
    logic idWe;        // store identity byte at byte index
    logic hdrWe;       // store header byte at byte index
    logic loadArm;     // copy header into write pointer / remaining count
    logic ramWr;       // issue one RAM write with the current byte
    logic useDefault;  // restore built-in identity
  } dpStrobe_t;

  localparam logic [7:0] MARK_IDS  = 8'hC0;
  localparam logic [7:0] MARK_LOAD = 8'hC2;
  localparam int ID_BYTES  = 6;
  localparam int HDR_BYTES = 4;

endpackage

// File: rtl/ebs_dpath.sv
module ebs_dpath
  import ebs_pkg::*;
#(
  parameter int RAM_DEPTH = 16384,
  parameter int RAM_AW = $clog2(RAM_DEPTH),
  parameter int EE_AW = 16,
  parameter logic [15:0] DEF_VID = 16'h04B4,
  parameter logic [15:0] DEF_PID = 16'h8613,
  parameter logic [15:0] DEF_DID = 16'hA001
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [7:0]        rdData,
  output logic [EE_AW-1:0]  eeAddr,
  output logic [2:0]        byteIdx,
  output logic              lenZero,
  output logic              overRange,
  output logic              lastByte,
  output logic              ramWe,
  output logic [RAM_AW-1:0] ramAddr,
  output logic [7:0]        ramData,
  output logic [15:0]       vendorId,
  output logic [15:0]       productId,
  output logic [15:0]       releaseId
);

  localparam int ID_W  = ID_BYTES * 8;
  localparam int HDR_W = HDR_BYTES * 8;
  localparam int SUM_W = 17;
  localparam logic [SUM_W-1:0] DEPTH_W = SUM_W'(RAM_DEPTH);
  localparam logic [ID_W-1:0] ID_DEF = {DEF_DID, DEF_PID, DEF_VID};

  logic [ID_W-1:0]   idVec;
  logic [HDR_W-1:0]  hdrVec;
  logic [15:0]       lenReg, startReg, remaining;
  logic [RAM_AW-1:0] wrPtr;
  logic [SUM_W-1:0]  loadEnd;

  // EEPROM address and byte index
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eeAddr  <= '0;
      byteIdx <= '0;
    end else begin
      if (stb.nextAddr) eeAddr <= eeAddr + 1'b1;
      if (stb.clrCnt) byteIdx <= '0;
      else if (stb.idWe || stb.hdrWe) byteIdx <= byteIdx + 1'b1;
    end
  end

  // identity byte slots, low byte first
  for (genvar g = 0; g < ID_BYTES; g++) begin : gIdSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) idVec[g*8 +: 8] <= ID_DEF[g*8 +: 8];
      else if (stb.useDefault) idVec[g*8 +: 8] <= ID_DEF[g*8 +: 8];
      else if (stb.idWe && byteIdx == 3'(g)) idVec[g*8 +: 8] <= rdData;
    end
  end

  // header byte slots: length then start address, low byte first
  for (genvar g = 0; g < HDR_BYTES; g++) begin : gHdrSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) hdrVec[g*8 +: 8] <= '0;
      else if (stb.hdrWe && byteIdx == 3'(g)) hdrVec[g*8 +: 8] <= rdData;
    end
  end

  assign lenReg   = hdrVec[15:0];
  assign startReg = hdrVec[31:16];
  assign loadEnd  = {1'b0, startReg} + {1'b0, lenReg};

  assign lenZero   = (lenReg == '0);
  assign overRange = (loadEnd > DEPTH_W);
  assign lastByte  = (remaining == 16'd1);

  // RAM write sequencing; outputs are registered
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      remaining <= '0;
      ramWe     <= 1'b0;
      ramAddr   <= '0;
      ramData   <= '0;
    end else begin
      ramWe <= 1'b0;
      if (stb.loadArm) begin
        wrPtr     <= startReg[RAM_AW-1:0];
        remaining <= lenReg;
      end else if (stb.ramWr) begin
        ramWe     <= 1'b1;
        ramAddr   <= wrPtr;
        ramData   <= rdData;
        wrPtr     <= wrPtr + 1'b1;
        remaining <= remaining - 1'b1;
      end
    end
  end

  assign vendorId  = idVec[15:0];
  assign productId = idVec[31:16];
  assign releaseId = idVec[47:32];

  AST_WR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> ((SUM_W'(ramAddr) >= SUM_W'(startReg)) && (SUM_W'(ramAddr) < loadEnd))); // R8

endmodule

// File: rtl/ebs_ctrl.sv
module ebs_ctrl
  import ebs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rdAck,
  input  logic       rdNak,
  input  logic [7:0] rdData,
  input  logic [2:0] byteIdx,
  input  logic       lenZero,
  input  logic       overRange,
  input  logic       lastByte,
  output dpStrobe_t  stb,
  output logic       rdReq,
  output logic       bootDone,
  output logic       bootErr,
  output logic [1:0] bootMode
);

  localparam logic [2:0] ID_LAST  = 3'(ID_BYTES - 1);
  localparam logic [2:0] HDR_LAST = 3'(HDR_BYTES - 1);

  bootState_t state, nxt;
  bootMode_t  modeQ, nMode;
  logic       errQ, nErr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_MARK;
      modeQ <= MODE_DEFAULT;
      errQ  <= 1'b0;
    end else begin
      state <= nxt;
      modeQ <= nMode;
      errQ  <= nErr;
    end
  end

  always_comb begin
    stb   = '0;
    nxt   = state;
    nMode = modeQ;
    nErr  = errQ;
    unique case (state)
      S_MARK: begin
        if (rdNak) nxt = S_DONE;  // no device: quiet fallback
        else if (rdAck) begin
          stb.nextAddr = 1'b1;
          stb.clrCnt   = 1'b1;
          if (rdData == MARK_IDS) nxt = S_IDS;
          else if (rdData == MARK_LOAD) nxt = S_HDR;
          else nxt = S_DONE;
        end
      end
      S_IDS: begin
        if (rdNak) begin
          nxt = S_DONE;
          stb.useDefault = 1'b1;
          nErr = 1'b1;
        end else if (rdAck) begin
          stb.nextAddr = 1'b1;
          stb.idWe     = 1'b1;
          if (byteIdx == ID_LAST) begin
            nxt   = S_DONE;
            nMode = MODE_IDS;
          end
        end
      end
      S_HDR: begin
        if (rdNak) begin
          nxt  = S_DONE;
          nErr = 1'b1;
        end else if (rdAck) begin
          stb.nextAddr = 1'b1;
          stb.hdrWe    = 1'b1;
          if (byteIdx == HDR_LAST) nxt = S_CHECK;
        end
      end
      S_CHECK: begin
        if (overRange) begin
          nxt  = S_DONE;
          nErr = 1'b1;
        end else if (lenZero) begin
          nxt   = S_DONE;
          nMode = MODE_LOAD;
        end else begin
          stb.loadArm = 1'b1;
          nxt = S_DATA;
        end
      end
      S_DATA: begin
        if (rdNak) begin
          nxt  = S_DONE;
          nErr = 1'b1;
        end else if (rdAck) begin
          stb.nextAddr = 1'b1;
          stb.ramWr    = 1'b1;
          if (lastByte) nxt = S_FLUSH;
        end
      end
      S_FLUSH: begin
        nxt   = S_DONE;
        nMode = MODE_LOAD;
      end
      S_DONE: nxt = S_DONE;
      default: nxt = S_DONE;
    endcase
  end

  assign rdReq    = (state == S_MARK) || (state == S_IDS) ||
                    (state == S_HDR) || (state == S_DATA);
  assign bootDone = (state == S_DONE);
  assign bootErr  = errQ;
  assign bootMode = modeQ;

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    bootDone |=> bootDone); // R10

  AST_NO_REQ_DONE: assert property (@(posedge clk) disable iff (!rstN)
    bootDone |-> !rdReq); // R10

  AST_ERR_MODE_DEFAULT: assert property (@(posedge clk) disable iff (!rstN)
    (bootDone && bootErr) |-> (bootMode == MODE_DEFAULT)); // R7

endmodule

// File: rtl/eeprom_boot_sel.sv
module eeprom_boot_sel
  import ebs_pkg::*;
#(
  parameter int RAM_DEPTH = 16384,
  parameter int RAM_AW = $clog2(RAM_DEPTH),
  parameter logic [15:0] DEF_VID = 16'h04B4,
  parameter logic [15:0] DEF_PID = 16'h8613,
  parameter logic [11:0] CHIP_REV = 12'h001
) (
  input  logic              clk,
  input  logic              rstN,
  output logic              rdReq,
  output logic [15:0]       rdAddr,
  input  logic              rdAck,
  input  logic              rdNak,
  input  logic [7:0]        rdData,
  output logic              ramWe,
  output logic [RAM_AW-1:0] ramAddr,
  output logic [7:0]        ramData,
  output logic [15:0]       vendorId,
  output logic [15:0]       productId,
  output logic [15:0]       releaseId,
  output logic [1:0]        bootMode,
  output logic              bootErr,
  output logic              bootDone,
  output logic              cpuHold
);

  localparam logic [15:0] DEF_DID = {4'hA, CHIP_REV};

  dpStrobe_t  stb;
  logic [2:0] byteIdx;
  logic       lenZero, overRange, lastByte;

  ebs_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .rdAck    (rdAck),
    .rdNak    (rdNak),
    .rdData   (rdData),
    .byteIdx  (byteIdx),
    .lenZero  (lenZero),
    .overRange(overRange),
    .lastByte (lastByte),
    .stb      (stb),
    .rdReq    (rdReq),
    .bootDone (bootDone),
    .bootErr  (bootErr),
    .bootMode (bootMode)
  );

  ebs_dpath #(
    .RAM_DEPTH(RAM_DEPTH),
    .RAM_AW   (RAM_AW),
    .EE_AW    (16),
    .DEF_VID  (DEF_VID),
    .DEF_PID  (DEF_PID),
    .DEF_DID  (DEF_DID)
  ) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .rdData   (rdData),
    .eeAddr   (rdAddr),
    .byteIdx  (byteIdx),
    .lenZero  (lenZero),
    .overRange(overRange),
    .lastByte (lastByte),
    .ramWe    (ramWe),
    .ramAddr  (ramAddr),
    .ramData  (ramData),
    .vendorId (vendorId),
    .productId(productId),
    .releaseId(releaseId)
  );

  assign cpuHold = !bootDone;

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdAck && !rdNak) |=> $stable(rdAddr)); // R2

  AST_ERR_DEFAULTS: assert property (@(posedge clk) disable iff (!rstN)
    (bootDone && bootErr) |-> (vendorId == DEF_VID && productId == DEF_PID &&
                               releaseId == DEF_DID)); // R7

  AST_NO_WR_DONE: assert property (@(posedge clk) disable iff (!rstN)
    bootDone |-> !ramWe); // R10

endmodule

// File: tb/eeprom_boot_sel_test.sv
module eeprom_boot_sel_test;

  localparam int DEPTH = 16384;
  localparam int DVID = 16'h04B4;
  localparam int DPID = 16'h8613;
  localparam int DDID = 16'hA001;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rdReq;
  logic [15:0] rdAddr;
  logic        rdAck = 1'b0;
  logic        rdNak = 1'b0;
  logic [7:0]  rdData = 8'h00;
  logic        ramWe;
  logic [13:0] ramAddr;
  logic [7:0]  ramData;
  logic [15:0] vendorId, productId, releaseId;
  logic [1:0]  bootMode;
  logic        bootErr, bootDone, cpuHold;

  eeprom_boot_sel uut (
    .clk(clk), .rstN(rstN), .rdReq(rdReq), .rdAddr(rdAddr), .rdAck(rdAck),
    .rdNak(rdNak), .rdData(rdData), .ramWe(ramWe), .ramAddr(ramAddr),
    .ramData(ramData), .vendorId(vendorId), .productId(productId),
    .releaseId(releaseId), .bootMode(bootMode), .bootErr(bootErr),
    .bootDone(bootDone), .cpuHold(cpuHold)
  );

  always #5 clk = ~clk;

  logic [7:0] img [0:255];
  int  nakAt = -1;
  bit  respEn = 1'b0;
  int  reads, addrErrs, writes, wrErrs, wrAfterDone, expStart;
  int  checks = 0;
  int  bad = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // EEPROM responder
  initial begin
    forever begin
      @(negedge clk);
      rdAck = 1'b0;
      rdNak = 1'b0;
      if (respEn && rstN && rdReq) begin
        repeat ($urandom_range(0, 2)) @(negedge clk);
        if (int'(rdAddr) != reads) addrErrs++;
        if (nakAt == int'(rdAddr)) rdNak = 1'b1;
        else begin
          rdAck  = 1'b1;
          rdData = img[rdAddr[7:0]];
        end
        reads++;
        @(negedge clk);
        rdAck = 1'b0;
        rdNak = 1'b0;
      end
    end
  end

  // RAM write monitor
  always @(negedge clk) begin
    if (rstN && ramWe) begin
      if (int'(ramAddr) != expStart + writes || ramData != img[(5 + writes) & 255])
        wrErrs++;
      writes++;
      if (bootDone) wrAfterDone++;
    end
  end

  task automatic fillImg();
    for (int i = 0; i < 256; i++) img[i] = 8'($urandom);
  endtask

  task automatic run(input string req, input int eMode, input int eErr, input int eVid,
                     input int ePid, input int eDid, input int eWrites, input int eReads);
    bit doneSeen;
    respEn = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b0;
    reads = 0; addrErrs = 0; writes = 0; wrErrs = 0; wrAfterDone = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "rdReq", int'(rdReq), 1);
    chk("R1", "rdAddr", int'(rdAddr), 0);
    chk("R1", "cpuHold", int'(cpuHold), 1);
    chk("R1", "bootDone", int'(bootDone), 0);
    chk("R1", "bootMode", int'(bootMode), 0);
    respEn = 1'b1;
    doneSeen = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (bootDone) begin doneSeen = 1'b1; break; end
    end
    chk("R10", "done reached", int'(doneSeen), 1);
    repeat (4) @(negedge clk);
    chk(req, "bootMode", int'(bootMode), eMode);
    chk(req, "bootErr", int'(bootErr), eErr);
    chk(req, "vendorId", int'(vendorId), eVid);
    chk(req, "productId", int'(productId), ePid);
    chk(req, "releaseId", int'(releaseId), eDid);
    chk(req, "write count", writes, eWrites);
    chk("R4", "write addr/data errors", wrErrs, 0);
    chk(req, "read count", reads, eReads);
    chk("R2", "address order errors", addrErrs, 0);
    chk("R10", "done sticky", int'(bootDone), 1);
    chk("R10", "hold released", int'(cpuHold), 0);
    chk("R10", "no request after done", int'(rdReq), 0);
    chk("R10", "no write after done", wrAfterDone, 0);
  endtask

  // marker 0xC0; nakPos 0 means no abort, else abort at that address (1..6)
  task automatic scenIds(input int nakPos);
    int v, p, d;
    fillImg();
    img[0] = 8'hC0;
    v = {img[2], img[1]}; p = {img[4], img[3]}; d = {img[6], img[5]};
    nakAt = (nakPos == 0) ? -1 : nakPos;
    if (nakPos == 0) run("R3", 1, 0, v, p, d, 0, 7);
    else run("R7", 0, 1, DVID, DPID, DDID, 0, nakPos + 1);
  endtask

  // marker 0xC2; nakPos -1 none, else address of abort
  task automatic scenLoad(input int len, input int start, input int nakPos);
    fillImg();
    img[0] = 8'hC2;
    img[1] = 8'(len); img[2] = 8'(len >> 8);
    img[3] = 8'(start); img[4] = 8'(start >> 8);
    expStart = start;
    nakAt = nakPos;
    if (nakPos >= 1) begin
      if (nakPos <= 4) run("R7", 0, 1, DVID, DPID, DDID, 0, nakPos + 1);
      else run("R7", 0, 1, DVID, DPID, DDID, nakPos - 5, nakPos + 1);
    end else if (start + len > DEPTH) run("R8", 0, 1, DVID, DPID, DDID, 0, 5);
    else if (len == 0) run("R8", 2, 0, DVID, DPID, DDID, 0, 5);
    else run("R4", 2, 0, DVID, DPID, DDID, len, 5 + len);
  endtask

  task automatic scenOther(input logic [7:0] m);
    fillImg();
    img[0] = m;
    nakAt = -1;
    run("R5", 0, 0, DVID, DPID, DDID, 0, 1);
  endtask

  initial begin
    void'($urandom(32'd1234));
    // R6: no device
    fillImg(); nakAt = 0;
    run("R6", 0, 0, DVID, DPID, DDID, 0, 1);
    // R9: defaults seen with unknown marker
    scenOther(8'h55);
    scenOther(8'hC1);
    scenOther(8'hFF);
    scenIds(0);
    scenIds(1);
    scenIds(6);
    scenLoad(1, 0, -1);
    scenLoad(37, 200, -1);
    scenLoad(8, DEPTH - 8, -1);   // R8: ends exactly at last byte
    scenLoad(5, DEPTH - 4, -1);   // R8: one past the end
    scenLoad(16'hFFFF, 0, -1);    // R8: huge length
    scenLoad(0, 100, -1);         // R8: empty load
    scenLoad(10, 50, 3);          // R7: abort in header
    scenLoad(10, 50, 9);          // R7: abort mid data
    for (int it = 0; it < 10; it++) begin
      case ($urandom_range(0, 3))
        0: begin
          logic [7:0] m;
          m = 8'($urandom);
          if (m == 8'hC0 || m == 8'hC2) m = 8'h00;
          scenOther(m);
        end
        1: scenIds($urandom_range(0, 6));
        2: scenLoad($urandom_range(1, 40), $urandom_range(0, DEPTH - 40), -1);
        default: scenLoad(20, $urandom_range(0, 1000), $urandom_range(5, 24));
      endcase
    end
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule